// File: doc/BRIEF.md
# ATA Device Command Engine

This block is the command-handling core on the device side of an ATA-style disk. The host writes a sector count, a device/head byte, a control byte and a command opcode. The engine decodes the opcode and keeps the busy, ready, data-request and error status bits and the error byte up to date. It drives a DMA request line, and it decides after which sectors the host is interrupted.

A separate data path moves the sector bytes. That path reports two events to the engine: one pulse when a sector has been taken from or given to the media, and one pulse when the host side of the buffer has been emptied or filled. Each transfer command sets how often the engine interrupts: after every sector, once per programmed block, or once at the end. The interrupt pin follows an internal pending flag. The pin is masked while another device is selected or while interrupts are disabled. The pending flag stays set while masked, so the interrupt appears again when the mask is removed.

Top module: `ata_cmd_engine`

## Requirements
- R1: `irq` is high exactly when an interrupt is pending, device/head bit 4 equals the `DEV_SEL` parameter, and control bit 1 is 0. Changing either bit masks or unmasks the pin without clearing the pending interrupt.
- R2: A write to the command register (`wr_sel`=3) is ignored while the device is not selected, unless the opcode is 0x90 (diagnostic).
- R3: An accepted command first clears the pending interrupt, `dmarq`, DRQ (status bit 3), ERR (status bit 0), the interrupt countdown and any running busy timer.
- R4: An opcode outside the supported set sets ERR, loads 0x04 into the error byte and raises the interrupt.
- R5: Transfer opcodes: read 0x20/0x21, read-multiple 0xC4, write 0x30/0x31, write-multiple 0xC5, verify 0x40/0x41, read-DMA 0xC8, write-DMA 0xCA. On each `sector_done` the countdown decrements, and the sector count register decrements. An interrupt is raised when the countdown reaches zero or when the sector count was 1; the countdown is then reloaded. Single and multiple transfers start at 1. Multiple transfers reload with the block count and single transfers reload with 1. Verify and DMA transfers start at the full sector count. `sector_done` has no effect when no transfer is active.
- R6: For read-DMA, `dmarq` rises together with DRQ. Write commands raise DRQ as soon as they are accepted, and write-DMA also raises `dmarq` then. `buf_done` drops both. PIO commands never raise `dmarq`.
- R7: During a verify transfer DRQ stays low.
- R8: Opcode 0xC6 copies the sector count into the block count and interrupts at once. Opcodes 0xE3 (idle) and 0x70 (seek) clear the sector count and interrupt at once.
- R9: Opcodes 0x90, 0x10 (recalibrate) and 0xEF (set features) hold BSY (status bit 7) for `MIN_CMD_CYC` cycles, then drop BSY and raise the interrupt. 0x90 also loads 0x01 into the error byte.
- R10: A status read (`stat_rd`) clears the pending interrupt. It also sets DRDY (status bit 6) if `dev_ready` is high.
- R11: After reset, `status`=0x10 (bit 4 always 1), `error`=0x01, `sect_cnt`=0, and `irq` and `dmarq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register: 0 count, 1 device/head, 2 control, 3 command |
| wr_data | input | 8 | Host write data |
| stat_rd | input | 1 | Host status read strobe |
| sector_done | input | 1 | Data path finished one sector on the media side |
| buf_done | input | 1 | Host side of the sector buffer finished |
| dev_ready | input | 1 | Media ready, feeds DRDY |
| irq | output | 1 | Interrupt to host |
| dmarq | output | 1 | DMA request |
| status | output | 8 | Status byte |
| error | output | 8 | Error byte |
| sect_cnt | output | 8 | Sector count register |

## Verification
The assertions assume that the host strobes and the data path pulses are single-cycle. They also assume that a status read never lands in the same cycle as an event that raises an interrupt, and that `sector_done` and `buf_done` never arrive together. The stimulus follows these assumptions because every strobe is issued by its own task, one clock apart and on the falling edge. Pulses arrive only in the phase of a command where the data path would produce them.

// File: rtl/ata_cmd_pkg.sv
package ata_cmd_pkg;

  localparam logic [7:0] OP_READ     = 8'h20;
  localparam logic [7:0] OP_READ_NR  = 8'h21;
  localparam logic [7:0] OP_WRITE    = 8'h30;
  localparam logic [7:0] OP_WRITE_NR = 8'h31;
  localparam logic [7:0] OP_VERIFY   = 8'h40;
  localparam logic [7:0] OP_VERIFY_NR= 8'h41;
  localparam logic [7:0] OP_RECAL    = 8'h10;
  localparam logic [7:0] OP_SEEK     = 8'h70;
  localparam logic [7:0] OP_DIAG     = 8'h90;
  localparam logic [7:0] OP_RDMULT   = 8'hC4;
  localparam logic [7:0] OP_WRMULT   = 8'hC5;
  localparam logic [7:0] OP_SETBLK   = 8'hC6;
  localparam logic [7:0] OP_RDMA     = 8'hC8;
  localparam logic [7:0] OP_WDMA     = 8'hCA;
  localparam logic [7:0] OP_IDLE     = 8'hE3;
  localparam logic [7:0] OP_SETFEAT  = 8'hEF;

  localparam logic [7:0] ERRB_ABORT   = 8'h04;
  localparam logic [7:0] ERRB_DIAG_OK = 8'h01;

  typedef enum logic [1:0] {
    SEL_COUNT, SEL_DEVHEAD, SEL_CONTROL, SEL_COMMAND
  } reg_sel_e;

  typedef enum logic [2:0] {
    XF_NONE, XF_READ, XF_RDMULT, XF_VERIFY, XF_RDMA, XF_WRITE, XF_WRMULT, XF_WDMA
  } xfer_e;

  function automatic xfer_e xfer_of(input logic [7:0] op);
    case (op)
      OP_READ, OP_READ_NR:     return XF_READ;
      OP_RDMULT:               return XF_RDMULT;
      OP_VERIFY, OP_VERIFY_NR: return XF_VERIFY;
      OP_RDMA:                 return XF_RDMA;
      OP_WRITE, OP_WRITE_NR:   return XF_WRITE;
      OP_WRMULT:               return XF_WRMULT;
      OP_WDMA:                 return XF_WDMA;
      default:                 return XF_NONE;
    endcase
  endfunction

  function automatic logic is_timed(input logic [7:0] op);
    return (op == OP_DIAG) || (op == OP_RECAL) || (op == OP_SETFEAT);
  endfunction

  function automatic logic is_rd(input xfer_e x);
    return (x == XF_READ) || (x == XF_RDMULT) || (x == XF_VERIFY) || (x == XF_RDMA);
  endfunction

  function automatic logic is_wr(input xfer_e x);
    return (x == XF_WRITE) || (x == XF_WRMULT) || (x == XF_WDMA);
  endfunction

  function automatic logic is_multi(input xfer_e x);
    return (x == XF_RDMULT) || (x == XF_WRMULT);
  endfunction

  function automatic logic starts_full(input xfer_e x);
    return (x == XF_VERIFY) || (x == XF_RDMA) || (x == XF_WDMA);
  endfunction

endpackage

// File: rtl/ata_irq_gate.sv
module ata_irq_gate #(
  parameter bit DEV_SEL = 1'b0
)(
  input  logic pend,
  input  logic dev_bit,
  input  logic nien,
  output logic selected,
  output logic irq
);
  assign selected = (dev_bit == DEV_SEL);
  assign irq      = pend & selected & ~nien;
endmodule

// File: rtl/ata_int_pacer.sv
module ata_int_pacer #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic [W-1:0] reload_val,
  input  logic         last,
  output logic         fire
);
  logic [W-1:0] cd_q, cd_d;

  assign fire = step & ((cd_q == W'(1)) | last);

  always_comb begin
    cd_d = cd_q;
    if (load)      cd_d = load_val;
    else if (step) cd_d = fire ? reload_val : cd_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cd_q <= '0;
    else        cd_q <= cd_d;
  end
endmodule

// File: rtl/ata_busy_timer.sv
module ata_busy_timer #(
  parameter int CYC = 16
)(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(CYC + 1);
  logic [TW-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == TW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (start)      cnt_d = TW'(CYC);
    else if (abort) cnt_d = '0;
    else if (busy)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ata_cmd_engine.sv
module ata_cmd_engine
  import ata_cmd_pkg::*;
#(
  parameter bit DEV_SEL     = 1'b0,
  parameter int MIN_CMD_CYC = 16,
  parameter int DW          = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_rd,
  input  logic          sector_done,
  input  logic          buf_done,
  input  logic          dev_ready,
  output logic          irq,
  output logic          dmarq,
  output logic [DW-1:0] status,
  output logic [DW-1:0] error,
  output logic [DW-1:0] sect_cnt
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] sec_q, sec_d, blk_q, blk_d, ereg_q, ereg_d;
  logic          dev_q, dev_d, nien_q, nien_d;
  logic          pend_q, pend_d, dmarq_q, dmarq_d, drq_q, drq_d;
  logic          err_q, err_d, drdy_q, drdy_d;
  xfer_e         xfer_q, xfer_d, new_xfer;

  logic          dev_selected, cmd_wr, accept, step, sec_last, pace_fire;
  logic          tmr_busy, tmr_done;
  logic [DW-1:0] load_val, reload_val;

  assign cmd_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_COMMAND);
  assign accept   = cmd_wr && (dev_selected || wr_data == OP_DIAG);
  assign new_xfer = xfer_of(wr_data);
  assign step     = sector_done && (xfer_q != XF_NONE) && !accept;
  assign sec_last = (sec_q == ONE);

  assign load_val   = (new_xfer == XF_NONE) ? '0 : (starts_full(new_xfer) ? sec_q : ONE);
  assign reload_val = is_multi(xfer_q) ? blk_q : ONE;

  ata_irq_gate #(.DEV_SEL(DEV_SEL)) u_gate (
    .pend(pend_q), .dev_bit(dev_q), .nien(nien_q),
    .selected(dev_selected), .irq(irq)
  );

  ata_int_pacer #(.W(DW)) u_pace (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(load_val),
    .step(step), .reload_val(reload_val), .last(sec_last), .fire(pace_fire)
  );

  ata_busy_timer #(.CYC(MIN_CMD_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept && is_timed(wr_data)),
    .abort(accept), .busy(tmr_busy), .done(tmr_done)
  );

  always_comb begin
    sec_d = sec_q;   blk_d = blk_q;     ereg_d = ereg_q;
    dev_d = dev_q;   nien_d = nien_q;   pend_d = pend_q;
    dmarq_d = dmarq_q; drq_d = drq_q;   err_d = err_q;
    drdy_d = drdy_q; xfer_d = xfer_q;

    if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_COUNT:   sec_d  = wr_data;
        SEL_DEVHEAD: dev_d  = wr_data[4];
        SEL_CONTROL: nien_d = wr_data[1];
        default: ;
      endcase
    end

    if (stat_rd) begin
      pend_d = 1'b0;
      if (dev_ready) drdy_d = 1'b1;
    end
    if (tmr_done) pend_d = 1'b1;
    if (buf_done) begin
      drq_d = 1'b0;
      dmarq_d = 1'b0;
    end

    if (step) begin
      if (pace_fire) pend_d = 1'b1;
      sec_d = sec_q - 1'b1;
      if (sec_last) xfer_d = XF_NONE;
      if (is_rd(xfer_q) && xfer_q != XF_VERIFY) begin
        drq_d = 1'b1;
        dmarq_d = (xfer_q == XF_RDMA);
      end
      if (is_wr(xfer_q) && !sec_last) begin
        drq_d = 1'b1;
        dmarq_d = (xfer_q == XF_WDMA);
      end
    end

    if (accept) begin
      pend_d = 1'b0; dmarq_d = 1'b0; drq_d = 1'b0; err_d = 1'b0;
      xfer_d = new_xfer;
      if (is_wr(new_xfer)) begin
        drq_d = 1'b1;
        dmarq_d = (new_xfer == XF_WDMA);
      end else if (new_xfer == XF_NONE) begin
        case (wr_data)
          OP_DIAG:             ereg_d = ERRB_DIAG_OK;
          OP_RECAL, OP_SETFEAT: ;
          OP_SETBLK:           begin blk_d = sec_q; pend_d = 1'b1; end
          OP_IDLE, OP_SEEK:    begin sec_d = '0;    pend_d = 1'b1; end
          default:             begin err_d = 1'b1; ereg_d = ERRB_ABORT; pend_d = 1'b1; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;  blk_q <= '0;  ereg_q <= ERRB_DIAG_OK;
      dev_q <= 1'b0; nien_q <= 1'b0; pend_q <= 1'b0;
      dmarq_q <= 1'b0; drq_q <= 1'b0; err_q <= 1'b0;
      drdy_q <= 1'b0; xfer_q <= XF_NONE;
    end else begin
      sec_q <= sec_d;  blk_q <= blk_d;  ereg_q <= ereg_d;
      dev_q <= dev_d;  nien_q <= nien_d; pend_q <= pend_d;
      dmarq_q <= dmarq_d; drq_q <= drq_d; err_q <= err_d;
      drdy_q <= drdy_d; xfer_q <= xfer_d;
    end
  end

  assign dmarq    = dmarq_q;
  assign error    = ereg_q;
  assign sect_cnt = sec_q;
  assign status   = {tmr_busy, drdy_q, 1'b0, 1'b1, drq_q, 2'b00, err_q};
endmodule

// File: rtl/ata_cmd_engine_chk.sv
module ata_cmd_engine_chk
  import ata_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       stat_rd,
  input logic       sector_done,
  input logic       irq,
  input logic       dmarq,
  input logic [7:0] status,
  input logic [7:0] error,
  input logic       selected,
  input logic [2:0] xfer
);
  // R1: disabling interrupts masks the pin on the next cycle
  a_r1_nien_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel_e'(wr_sel) == SEL_CONTROL && wr_data[1]) |=> !irq);

  // R2: an unselected non-diagnostic command cannot raise ERR
  a_r2_unselected_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel_e'(wr_sel) == SEL_COMMAND && !selected && wr_data != OP_DIAG && !status[0])
    |=> !status[0]);

  // R3: an accepted seek leaves no error, data request or DMA request
  a_r3_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel_e'(wr_sel) == SEL_COMMAND && selected && wr_data == OP_SEEK)
    |=> (!status[0] && !status[3] && !dmarq));

  // R4: unsupported opcode aborts
  a_r4_unknown_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel_e'(wr_sel) == SEL_COMMAND && selected && wr_data == 8'h00)
    |=> (status[0] && error == ERRB_ABORT));

  // R6: a DMA request always comes with a data request
  a_r6_dmarq_has_drq: assert property (@(posedge clk) disable iff (!rst_n)
    dmarq |-> status[3]);

  // R7: verify never requests data
  a_r7_verify_no_drq: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer == 3'(XF_VERIFY)) |-> !status[3]);

  // R9: no interrupt while busy
  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> !irq);

  // R10: a status read with no competing event clears the interrupt
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !wr_en && !sector_done && !status[7]) |=> !irq);
endmodule

bind ata_cmd_engine ata_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .stat_rd(stat_rd), .sector_done(sector_done), .irq(irq), .dmarq(dmarq),
  .status(status), .error(error), .selected(dev_selected), .xfer(xfer_q)
);

// File: tb/sim_ata_cmd_engine.sv
module sim_ata_cmd_engine;
  localparam int B_MIN = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       stat_rd = 1'b0, sector_done = 1'b0, buf_done = 1'b0, dev_ready = 1'b1;
  logic       irq, dmarq;
  logic [7:0] status, error, sect_cnt;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ata_cmd_engine #(.MIN_CMD_CYC(B_MIN)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stat_rd(stat_rd), .sector_done(sector_done), .buf_done(buf_done),
    .dev_ready(dev_ready), .irq(irq), .dmarq(dmarq), .status(status),
    .error(error), .sect_cnt(sect_cnt)
  );

  // Behavioural reference model
  int m_sec, m_blk, m_ereg, m_dev, m_nien, m_pend, m_dmarq, m_drq, m_err, m_drdy;
  int m_xfer, m_cd, m_tmr;
  // xfer: 0 none 1 read 2 rdmult 3 verify 4 rdma 5 write 6 wrmult 7 wdma

  function automatic int op_xfer(int op);
    case (op)
      'h20, 'h21: return 1;
      'hC4: return 2;
      'h40, 'h41: return 3;
      'hC8: return 4;
      'h30, 'h31: return 5;
      'hC5: return 6;
      'hCA: return 7;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_sec = 0; m_blk = 0; m_ereg = 1; m_dev = 0; m_nien = 0; m_pend = 0;
    m_dmarq = 0; m_drq = 0; m_err = 0; m_drdy = 0; m_xfer = 0; m_cd = 0; m_tmr = 0;
  endtask

  task automatic model_step();
    bit acc, was_last;
    int op, nx;
    op = int'(wr_data);
    acc = wr_en && wr_sel == 2'd3 && (m_dev == 0 || op == 'h90);
    if (stat_rd) begin m_pend = 0; if (dev_ready) m_drdy = 1; end
    if (m_tmr > 0) begin m_tmr--; if (m_tmr == 0) m_pend = 1; end
    if (wr_en && wr_sel == 2'd0) m_sec = op;
    if (wr_en && wr_sel == 2'd1) m_dev = int'(wr_data[4]);
    if (wr_en && wr_sel == 2'd2) m_nien = int'(wr_data[1]);
    if (buf_done) begin m_drq = 0; m_dmarq = 0; end
    if (sector_done && m_xfer != 0 && !acc) begin
      was_last = (m_sec == 1);
      m_cd = (m_cd - 1) & 255;
      if (m_cd == 0 || was_last) begin
        m_pend = 1;
        m_cd = (m_xfer == 2 || m_xfer == 6) ? m_blk : 1;
      end
      m_sec = (m_sec - 1) & 255;
      if (m_xfer == 1 || m_xfer == 2 || m_xfer == 4) begin m_drq = 1; m_dmarq = (m_xfer == 4); end
      if (m_xfer >= 5 && !was_last) begin m_drq = 1; m_dmarq = (m_xfer == 7); end
      if (was_last) m_xfer = 0;
    end
    if (acc) begin
      m_pend = 0; m_dmarq = 0; m_drq = 0; m_err = 0; m_tmr = 0;
      nx = op_xfer(op);
      m_xfer = nx;
      m_cd = (nx == 0) ? 0 : ((nx == 3 || nx == 4 || nx == 7) ? m_sec : 1);
      if (nx >= 5) begin m_drq = 1; m_dmarq = (nx == 7); end
      else if (nx == 0) begin
        case (op)
          'h90: begin m_ereg = 1; m_tmr = B_MIN; end
          'h10, 'hEF: m_tmr = B_MIN;
          'hC6: begin m_blk = m_sec; m_pend = 1; end
          'hE3, 'h70: begin m_sec = 0; m_pend = 1; end
          default: begin m_err = 1; m_ereg = 4; m_pend = 1; end
        endcase
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle compare, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R1 irq", int'(irq), int'(m_pend != 0 && m_dev == 0 && m_nien == 0));
      chk("R6 dmarq", int'(dmarq), m_dmarq);
      chk("R3 status", int'(status),
          ((m_tmr > 0) << 7) | (m_drdy << 6) | 'h10 | (m_drq << 3) | m_err);
      chk("R4 error", int'(error), m_ereg);
      chk("R8 sect_cnt", int'(sect_cnt), m_sec);
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_up();
    end
  end

  task automatic put(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic stat();  stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; endtask
  task automatic sdone(); sector_done = 1'b1; @(negedge clk); sector_done = 1'b0; endtask
  task automatic bdone(); buf_done = 1'b1; @(negedge clk); buf_done = 1'b0; endtask
  task automatic gap(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    gap(3);
    rst_n = 1'b1;
    gap(1);
    chk("R11 status", int'(status), 'h10);
    chk("R11 error", int'(error), 'h01);
    chk("R11 irq", int'(irq), 0);
    chk("R11 dmarq", int'(dmarq), 0);
    chk("R11 sect_cnt", int'(sect_cnt), 0);
    stat();
    chk("R10 drdy", int'(status), 'h50);

    put(2'd3, 8'h00);
    chk("R4 irq", int'(irq), 1);
    chk("R4 status", int'(status), 'h51);
    chk("R4 error", int'(error), 'h04);
    put(2'd2, 8'h02); chk("R1 masked nien", int'(irq), 0);
    put(2'd2, 8'h00); chk("R1 kept nien", int'(irq), 1);
    put(2'd1, 8'h10); chk("R1 masked dev", int'(irq), 0);
    put(2'd1, 8'h00); chk("R1 kept dev", int'(irq), 1);
    stat(); chk("R10 clear", int'(irq), 0);

    put(2'd0, 8'h09); put(2'd3, 8'h70);
    chk("R8 seek count", int'(sect_cnt), 0);
    chk("R8 seek irq", int'(irq), 1);
    chk("R3 err cleared", int'(status[0]), 0);
    stat();

    put(2'd1, 8'h10); put(2'd3, 8'h00);
    chk("R2 ignored err", int'(status[0]), 0);
    chk("R2 ignored ereg", int'(error), 'h04);
    put(2'd3, 8'h90);
    chk("R9 busy", int'(status[7]), 1);
    chk("R9 diag code", int'(error), 'h01);
    gap(B_MIN - 1); chk("R9 still busy", int'(status[7]), 1);
    gap(1);
    chk("R9 busy done", int'(status[7]), 0);
    chk("R1 unselected", int'(irq), 0);
    put(2'd1, 8'h00); chk("R1 reselected", int'(irq), 1);
    stat();

    put(2'd0, 8'd3); put(2'd3, 8'hC6); chk("R8 setblk irq", int'(irq), 1); stat();
    put(2'd0, 8'd5); put(2'd3, 8'hC4);
    chk("R3 drq off", int'(status[3]), 0);
    sdone(); chk("R5 first", int'(irq), 1); chk("R5 drq", int'(status[3]), 1);
    stat(); bdone(); sdone(); chk("R5 mid", int'(irq), 0);
    bdone(); sdone(); chk("R5 mid2", int'(irq), 0);
    bdone(); sdone(); chk("R5 block", int'(irq), 1);
    stat(); bdone(); sdone(); chk("R5 last", int'(irq), 1);
    chk("R5 count", int'(sect_cnt), 0);
    stat(); bdone();

    put(2'd0, 8'd3); put(2'd3, 8'h40);
    sdone(); chk("R7 no drq", int'(status[3]), 0); chk("R5 verify wait", int'(irq), 0);
    sdone(); chk("R5 verify wait2", int'(irq), 0);
    sdone(); chk("R5 verify end", int'(irq), 1); chk("R7 no drq end", int'(status[3]), 0);
    stat();

    put(2'd0, 8'd2); put(2'd3, 8'hC8);
    sdone(); chk("R6 rdma req", int'(dmarq), 1); chk("R5 rdma wait", int'(irq), 0);
    bdone(); chk("R6 rdma drop", int'(dmarq), 0);
    sdone(); chk("R5 rdma end", int'(irq), 1); chk("R6 rdma req2", int'(dmarq), 1);
    stat(); bdone();

    put(2'd0, 8'd2); put(2'd3, 8'hCA);
    chk("R6 wdma at once", int'(dmarq), 1); chk("R6 wdma drq", int'(status[3]), 1);
    put(2'd3, 8'h70);
    chk("R3 dmarq cleared", int'(dmarq), 0); chk("R3 drq cleared", int'(status[3]), 0);
    stat();

    put(2'd0, 8'd2); put(2'd3, 8'hCA);
    bdone(); chk("R6 wdma drop", int'(dmarq), 0);
    sdone(); chk("R6 wdma again", int'(dmarq), 1); chk("R5 wdma wait", int'(irq), 0);
    bdone(); sdone();
    chk("R5 wdma end", int'(irq), 1); chk("R6 wdma idle", int'(dmarq), 0);
    stat();

    put(2'd0, 8'd2); put(2'd3, 8'h30);
    chk("R6 pio drq", int'(status[3]), 1); chk("R6 pio no dma", int'(dmarq), 0);
    bdone(); sdone(); chk("R5 write each", int'(irq), 1); chk("R6 pio drq2", int'(status[3]), 1);
    stat(); bdone(); sdone(); chk("R5 write end", int'(irq), 1); chk("R6 pio done", int'(status[3]), 0);
    stat();

    put(2'd0, 8'd7); put(2'd3, 8'hE3);
    chk("R8 idle count", int'(sect_cnt), 0); chk("R8 idle irq", int'(irq), 1);
    stat();
    put(2'd3, 8'hEF); chk("R9 setfeat busy", int'(status[7]), 1);
    gap(B_MIN); chk("R9 setfeat irq", int'(irq), 1); chk("R9 error kept", int'(error), 'h01);
    stat();
    put(2'd3, 8'h10); chk("R9 recal busy", int'(status[7]), 1);
    gap(B_MIN); chk("R9 recal irq", int'(irq), 1);
    stat();

    put(2'd0, 8'd4); sdone();
    chk("R5 idle pulse count", int'(sect_cnt), 4);
    chk("R5 idle pulse irq", int'(irq), 0);

    gap(3);
    finish_up();
  end
endmodule